// File: doc/BRIEF.md
# Phase-Pair Capture Pulse Controller

This block sits in the test clock path of one clock domain whose flops are split across two phase-shifted clocks of the same frequency. Each phase has its own clock-gating channel. During shift, both gated outputs follow the slow test clock, so the scan chains behave as if one clock drives them. When scan enable falls, the block lets exactly one launch pulse through on one channel. A programmed number of test-clock edges later, it lets exactly one capture pulse through on the other channel. Stuck-at faults on paths between the two phase groups are therefore captured at staggered times, and no hold fixing between the groups is needed.

Each channel has a 4-bit delay value. A direction input selects which channel launches, so paths can be covered A-to-B or B-to-A. The delays and the direction are sampled only on rising test-clock edges with scan enable high, and they stay frozen for the whole capture window. A configuration that would let the capture pulse come no later than the launch pulse is flagged as an error, and both channels then stay silent. A done flag marks the end of the pair and clears when shift resumes, which rearms the block.

Top module: `phase_pair_pulse_ctrl`

## Requirements
- R1: While scan_en is high, pulse_a and pulse_b both equal test_clk.
- R2: Edge 1 is the first rising test_clk edge at which scan_en is low. The launching channel emits exactly one pulse per capture window, and that pulse is the test_clk high phase that begins at edge d+2, where d is that channel's sampled delay.
- R3: The capturing channel follows the same rule with its own sampled delay, and also emits exactly one pulse per window.
- R4: b_launches = 0 makes channel A (pulse_a) launch and B capture, and b_launches = 1 does the reverse. The bit is sampled only at rising edges with scan_en high, and a change while scan_en is low has no effect on the current window.
- R5: dly_a and dly_b are sampled only at rising edges with scan_en high. A change while scan_en is low has no effect on the current window.
- R6: cfg_err is high whenever the sampled launch delay is greater than or equal to the sampled capture delay. Equal delays are included. While cfg_err is high, both outputs stay low throughout the capture window.
- R7: done rises at the edge where the capture pulse begins (edge dc+2, where dc is the capture delay). It stays high while scan_en stays low. It clears at the first rising edge with scan_en high, and it never rises while cfg_err is high.
- R8: Both outputs are low whenever test_clk is low, so no partial or glitch pulse is produced.
- R9: After reset, done is low and both sampled delays are zero, so cfg_err reads high.
- R10: After scan_en returns high and falls again, a new launch and capture pair is produced under the newly sampled settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Slow test clock (shift and capture timing) |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | High for shift, low for the capture window |
| b_launches | input | 1 | 0: channel A launches; 1: channel B launches |
| dly_a | input | DLY_W | Delay value of channel A |
| dly_b | input | DLY_W | Delay value of channel B |
| pulse_a | output | 1 | Gated clock for phase A |
| pulse_b | output | 1 | Gated clock for phase B |
| done | output | 1 | High once both pulses of the window are issued |
| cfg_err | output | 1 | Launch delay not below capture delay |

## Verification
The bench drives both directions and several delay pairs, including a launch delay of 0 and a capture delay of 15. A counter that is off by one edge, or a counter that does not start fresh at the first low edge, shows up as a pulse one high phase early or late. Equal delays and reversed delays check that the error path silences both channels; a design that only compared for equality would fire out of order on the reversed case. Changing the direction and the delays in the middle of a window, and holding windows much longer than the largest delay, expose a design that samples its settings live or whose saturated counter wraps and fires a second time. Back-to-back windows show whether done and the counter really rearm when shift resumes.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
    localparam int NCH  = 2;
    localparam int CH_A = 0;
    localparam int CH_B = 1;
endpackage

// File: rtl/pcp_clk_gate.sv
module pcp_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    // enable captured only while the clock is low, held through the high phase
    always_latch begin
        if (!clk) en_lat <= en;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/pcp_cfg_hold.sv
module pcp_cfg_hold
    import pcp_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scan_en,
    input  logic                      b_launches,
    input  logic [DLY_W-1:0]          dly_a,
    input  logic [DLY_W-1:0]          dly_b,
    output logic [NCH-1:0][DLY_W-1:0] dly_q,
    output logic                      launch_b_q,
    output logic                      cfg_err
);
    typedef struct packed {
        logic [NCH-1:0][DLY_W-1:0] dly;
        logic                      launch_b;
    } cfg_t;

    cfg_t s_d, s_q;
    logic [DLY_W-1:0] launch_dly, capture_dly;

    always_comb begin
        s_d = s_q;
        if (scan_en) begin
            s_d.dly[CH_A] = dly_a;
            s_d.dly[CH_B] = dly_b;
            s_d.launch_b  = b_launches;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        launch_dly  = s_q.launch_b ? s_q.dly[CH_B] : s_q.dly[CH_A];
        capture_dly = s_q.launch_b ? s_q.dly[CH_A] : s_q.dly[CH_B];
        cfg_err     = (launch_dly >= capture_dly);
    end

    assign dly_q      = s_q.dly;
    assign launch_b_q = s_q.launch_b;

    // R4 R5: settings frozen through a capture window
    assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && $past(!scan_en)) |-> ($stable(dly_q) && $stable(launch_b_q)));
endmodule

// File: rtl/pcp_seq.sv
module pcp_seq
    import pcp_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scan_en,
    input  logic [NCH-1:0][DLY_W-1:0] dly,
    input  logic                      launch_b,
    input  logic                      cfg_err,
    output logic [NCH-1:0]            fire_q,
    output logic                      done_q
);
    localparam int               CNT_W   = DLY_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(2 ** DLY_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [NCH-1:0]   fire;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;
    logic cap_idx;

    assign cap_idx = launch_b ? 1'(CH_A) : 1'(CH_B);

    always_comb begin
        s_d = s_q;
        if (scan_en) begin
            s_d.cnt  = '0;
            s_d.fire = '0;
            s_d.done = 1'b0;
        end else begin
            // saturate so a long window never matches a delay twice
            if (s_q.cnt != CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
            for (int i = 0; i < NCH; i++) begin
                s_d.fire[i] = !cfg_err && (s_q.cnt == {1'b0, dly[i]});
            end
            s_d.done = s_q.done | s_q.fire[cap_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fire_q = s_q.fire;
    assign done_q = s_q.done;

    // R2 R3: a channel enable never lasts two edges
    assert_one_shot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire_q) |=> ((fire_q & $past(fire_q)) == '0));

    // R1: nothing armed once shift is seen
    assert_quiet_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (fire_q == '0 && !done_q));

    // R6: error configuration silences both channels
    assert_err_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (fire_q == '0));

    // R6: both channels never enabled together
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire_q[CH_A] && fire_q[CH_B]));

    // R7: done only rises right after the capture enable
    assert_done_after_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(fire_q[cap_idx]));
endmodule

// File: rtl/phase_pair_pulse_ctrl.sv
module phase_pair_pulse_ctrl
    import pcp_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             test_clk,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic             b_launches,
    input  logic [DLY_W-1:0] dly_a,
    input  logic [DLY_W-1:0] dly_b,
    output logic             pulse_a,
    output logic             pulse_b,
    output logic             done,
    output logic             cfg_err
);
    logic [NCH-1:0][DLY_W-1:0] dly_q;
    logic                      launch_b_q;
    logic [NCH-1:0]            fire_q;
    logic [NCH-1:0]            gclk;

    pcp_cfg_hold #(.DLY_W(DLY_W)) u_cfg (
        .clk        (test_clk),
        .rst_n      (rst_n),
        .scan_en    (scan_en),
        .b_launches (b_launches),
        .dly_a      (dly_a),
        .dly_b      (dly_b),
        .dly_q      (dly_q),
        .launch_b_q (launch_b_q),
        .cfg_err    (cfg_err)
    );

    pcp_seq #(.DLY_W(DLY_W)) u_seq (
        .clk      (test_clk),
        .rst_n    (rst_n),
        .scan_en  (scan_en),
        .dly      (dly_q),
        .launch_b (launch_b_q),
        .cfg_err  (cfg_err),
        .fire_q   (fire_q),
        .done_q   (done)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pcp_clk_gate u_gate (
            .clk  (test_clk),
            .en   (scan_en | fire_q[g]),
            .gclk (gclk[g])
        );
    end

    assign pulse_a = gclk[CH_A];
    assign pulse_b = gclk[CH_B];
endmodule

// File: tb/sim_phase_pair_pulse_ctrl.sv
`timescale 1ns/1ps
module sim_phase_pair_pulse_ctrl;
    logic       test_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_en = 1'b1;
    logic       b_launches = 1'b0;
    logic [3:0] dly_a = 4'd0;
    logic [3:0] dly_b = 4'd0;
    logic       pulse_a, pulse_b, done, cfg_err;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    checking = 1'b0;
    string scen = "reset";

    // reference state
    int m_da = 0, m_db = 0, m_dir = 0, k = 0;

    always #2.5 test_clk = ~test_clk;

    phase_pair_pulse_ctrl u0 (
        .test_clk(test_clk), .rst_n(rst_n), .scan_en(scan_en), .b_launches(b_launches),
        .dly_a(dly_a), .dly_b(dly_b), .pulse_a(pulse_a), .pulse_b(pulse_b),
        .done(done), .cfg_err(cfg_err)
    );

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s [%s] t=%0t: actual %0b expected %0b", tag, what, scen, $time, act, exp);
        end
    endtask

    function automatic bit m_err();
        int l, c;
        l = m_dir ? m_db : m_da;
        c = m_dir ? m_da : m_db;
        return l >= c;
    endfunction

    // high-phase model and compare
    always @(posedge test_clk) begin
        bit e_a, e_b, e_done, err, se;
        string ta, tb;
        se = scan_en;
        if (!rst_n) begin
            k = 0; m_da = 0; m_db = 0; m_dir = 0;
        end else if (se) begin
            k = 0; m_da = int'(dly_a); m_db = int'(dly_b); m_dir = int'(b_launches);
        end else begin
            k++;
        end
        err    = m_err();
        e_a    = se || (!err && k == m_da + 2);
        e_b    = se || (!err && k == m_db + 2);
        e_done = !se && !err && (k >= (m_dir ? m_da : m_db) + 2);
        ta = se ? "R1" : err ? "R6" : (m_dir == 0) ? "R2" : "R3";
        tb = se ? "R1" : err ? "R6" : (m_dir == 1) ? "R2" : "R3";
        #1;
        if (checking) begin
            chk(pulse_a, e_a, ta, "pulse_a high phase");
            chk(pulse_b, e_b, tb, "pulse_b high phase");
            chk(done, e_done, "R7", "done");
            chk(cfg_err, err, "R6", "cfg_err");
        end
    end

    // R8: low phase always quiet
    always @(negedge test_clk) begin
        #1;
        if (checking) begin
            chk(pulse_a, 1'b0, "R8", "pulse_a low phase");
            chk(pulse_b, 1'b0, "R8", "pulse_b low phase");
        end
    end

    task automatic window(input int da, input int db, input bit dir, input int len, input string s);
        @(negedge test_clk);
        scen = s; dly_a = 4'(da); dly_b = 4'(db); b_launches = dir; scan_en = 1'b1;
        repeat (3) @(negedge test_clk);
        scan_en = 1'b0;
        repeat (len) @(negedge test_clk);
        scan_en = 1'b1;
    endtask

    task automatic run();
        repeat (3) @(negedge test_clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state before any sampling edge
        chk(done, 1'b0, "R9", "done after reset");
        chk(cfg_err, 1'b1, "R9", "cfg_err after reset");
        checking = 1'b1;
        repeat (4) @(negedge test_clk);                  // R1 shift pass-through
        window(2, 5, 1'b0, 12, "A launches");            // R2 R3
        window(6, 1, 1'b1, 12, "B launches R4");         // R4
        window(0, 15, 1'b0, 24, "extreme delays");       // R2 R3 boundary
        window(15, 0, 1'b1, 40, "extreme B, long window R8");
        window(3, 3, 1'b0, 10, "equal delays R6");
        window(7, 4, 1'b0, 12, "reversed order R6");
        // R4 R5: settings changed mid-window are ignored
        @(negedge test_clk);
        scen = "mid-window change R4 R5";
        dly_a = 4'd1; dly_b = 4'd3; b_launches = 1'b0; scan_en = 1'b1;
        repeat (2) @(negedge test_clk);
        scan_en = 1'b0;
        @(negedge test_clk);
        dly_a = 4'd9; dly_b = 4'd0; b_launches = 1'b1;
        repeat (10) @(negedge test_clk);
        scan_en = 1'b1;
        // R10: rearm back to back
        window(4, 8, 1'b0, 14, "rearm first R10");
        window(5, 2, 1'b1, 9, "rearm second R10");
        window(0, 1, 1'b0, 5, "short window R10");
        repeat (4) @(negedge test_clk);
    endtask

    initial begin
        fork
            run();
            begin
                #500us;
                n_fail++;
                $display("FAIL watchdog: actual hung expected finished");
            end
        join_any
        checking = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule